// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery Monitor

This block keeps the transmit and receive error counters of a CAN node and turns them into three state flags: warning, error-passive and bus-off. The counters are not driven by frame decoding here; an upstream protocol engine hands in ready-made step commands: an amount to add and a single-step decrement for each counter. When the transmit counter passes 255, the node goes bus-off. The block then forces its initialization bit, and all counting and bus-event reporting stop.

Software starts recovery by writing the initialization bit to zero while the node is bus-off. From then on the block watches the strobed receive level. Every time it sees eleven recessive samples in a row, it writes the Bit0 code into the last-error-code field, so software can follow how far recovery has got. When enough runs have been seen, bus-off clears and both counters return to zero. Writing the initialization bit during recovery has no effect on the sequence.

Top module: `can_fault_confine`

## Requirements
- R1: `warn_o` is high exactly when either error counter is 96 or more. It is low once both counters are 95 or less.
- R2: `passive_o` is high exactly when either error counter is 128 or more.
- R3: `bus_off_o` rises in the cycle after an add command takes the transmit counter above 255. While bus-off, the counter commands and `evt_valid_i` have no effect on `tec_o`, `rec_o` or `lec_o`.
- R4: Entering bus-off sets `init_o` to 1 in the same cycle that `bus_off_o` rises, even if software had cleared it.
- R5: Recovery starts only on a CPU write of 0 to the initialization bit while the node is bus-off. A write of 1 starts nothing, and recessive samples seen before the start are not counted.
- R6: During recovery, every 11 consecutive strobed recessive samples (`rx_bit_i` = 1) write code 5 into `lec_o`.
- R7: A dominant strobed sample during recovery restarts the current 11-sample run. Runs already completed are kept.
- R8: Writing the initialization bit (either value) during recovery neither shortens nor restarts the sequence.
- R9: On the 128th completed run, bus-off clears and both counters become zero. The warning and passive flags clear with them.
- R10: `lec_o` codes are 0 none, 1 stuff, 2 form, 3 ack, 4 Bit1, 5 Bit0, 6 CRC. A bus event writes its code. A CPU write stores any value, and a stored 7 stays until the next bus event. A bus event in the same cycle as a CPU write wins.
- R11: After reset the counters, `lec_o` and `bus_off_o` are 0 and `init_o` is 1.
- R12: A decrement of a counter at zero leaves it at zero. The receive counter saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tec_add_i | input | 4 | Amount added to the transmit error counter this cycle |
| tec_dec_i | input | 1 | Decrement the transmit error counter by one |
| rec_add_i | input | 4 | Amount added to the receive error counter this cycle |
| rec_dec_i | input | 1 | Decrement the receive error counter by one |
| bit_strobe_i | input | 1 | Sample point strobe for `rx_bit_i` |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| evt_valid_i | input | 1 | A bus error/event code is reported this cycle |
| evt_code_i | input | 3 | Code of the reported bus event |
| cpu_init_wr_i | input | 1 | CPU write strobe for the initialization bit |
| cpu_init_val_i | input | 1 | Value written to the initialization bit |
| cpu_lec_wr_i | input | 1 | CPU write strobe for the last-error-code field |
| cpu_lec_val_i | input | 3 | Value written to the last-error-code field |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive flag |
| bus_off_o | output | 1 | Bus-off flag |
| init_o | output | 1 | Initialization bit |
| lec_o | output | 3 | Last error code |

## Verification
The assertions check the cycle-level relations on every cycle. Bus-off never rises without the initialization bit rising with it. Recovery is only ever active while the node is bus-off, and it only begins after a write of zero. The count of completed runs never goes down while recovery lasts. The transmit counter stays frozen during bus-off. The error code changes only when something causes it to. Only the bench scenarios can show the exact thresholds at 96, 128 and 255, and that exactly 128 runs are needed even when a dominant glitch and initialization writes occur in the middle of recovery. They also show the persistence of code 7 and the priority between a bus event and a CPU write in the same cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_CPU   = 3'd7
    } lec_code_e;

    localparam int DEF_WARN_LIMIT    = 96;
    localparam int DEF_PASSIVE_LIMIT = 128;
    localparam int DEF_BOFF_LIMIT    = 255;
    localparam int DEF_RUN_BITS      = 11;
    localparam int DEF_RUNS_NEEDED   = 128;
    localparam int DEF_STEP_W        = 4;
endpackage

// File: rtl/cfc_counters.sv
module cfc_counters #(
    parameter int STEP_W        = can_fc_pkg::DEF_STEP_W,
    parameter int WARN_LIMIT    = can_fc_pkg::DEF_WARN_LIMIT,
    parameter int PASSIVE_LIMIT = can_fc_pkg::DEF_PASSIVE_LIMIT,
    parameter int BOFF_LIMIT    = can_fc_pkg::DEF_BOFF_LIMIT,
    localparam int REC_W        = $clog2(BOFF_LIMIT + 1),
    localparam int TEC_W        = REC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] tec_add_i,
    input  logic              tec_dec_i,
    input  logic [STEP_W-1:0] rec_add_i,
    input  logic              rec_dec_i,
    input  logic              clear_i,
    output logic [TEC_W-1:0]  tec_o,
    output logic [REC_W-1:0]  rec_o,
    output logic              boff_o,
    output logic              boff_enter_o,
    output logic              warn_o,
    output logic              passive_o
);
    localparam logic [TEC_W:0]   TEC_SAT  = {1'b0, {TEC_W{1'b1}}};
    localparam logic [TEC_W:0]   BOFF_LIM = (TEC_W+1)'(BOFF_LIMIT);
    localparam logic [REC_W:0]   REC_SAT  = {1'b0, {REC_W{1'b1}}};
    localparam logic [TEC_W-1:0] T_WARN   = TEC_W'(WARN_LIMIT);
    localparam logic [TEC_W-1:0] T_PASS   = TEC_W'(PASSIVE_LIMIT);
    localparam logic [REC_W-1:0] R_WARN   = REC_W'(WARN_LIMIT);
    localparam logic [REC_W-1:0] R_PASS   = REC_W'(PASSIVE_LIMIT);

    typedef struct packed {
        logic [TEC_W-1:0] tec;
        logic [REC_W-1:0] rec;
        logic             boff;
    } cnt_state_t;

    cnt_state_t     st_d, st_q;
    logic [TEC_W:0] tsum;
    logic [REC_W:0] rsum;

    always_comb begin
        st_d         = st_q;
        boff_enter_o = 1'b0;
        tsum         = {1'b0, st_q.tec} + (TEC_W+1)'(tec_add_i);
        rsum         = {1'b0, st_q.rec} + (REC_W+1)'(rec_add_i);
        if (tec_dec_i && tsum != '0) tsum = tsum - 1'b1;
        if (rec_dec_i && rsum != '0) rsum = rsum - 1'b1;
        if (tsum > TEC_SAT) tsum = TEC_SAT;
        if (rsum > REC_SAT) rsum = REC_SAT;
        if (clear_i) begin
            st_d.tec  = '0;
            st_d.rec  = '0;
            st_d.boff = 1'b0;
        end else if (!st_q.boff) begin
            st_d.tec = tsum[TEC_W-1:0];
            st_d.rec = rsum[REC_W-1:0];
            if (tsum > BOFF_LIM) begin
                st_d.boff    = 1'b1;
                boff_enter_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tec_o     = st_q.tec;
    assign rec_o     = st_q.rec;
    assign boff_o    = st_q.boff;
    assign warn_o    = (st_q.tec >= T_WARN) || (st_q.rec >= R_WARN);
    assign passive_o = (st_q.tec >= T_PASS) || (st_q.rec >= R_PASS);

    // R3
    tec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.boff && $past(st_q.boff)) |-> $stable(st_q.tec));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.boff) |-> (st_q.tec == '0 && st_q.rec == '0));
endmodule

// File: rtl/cfc_recovery.sv
module cfc_recovery #(
    parameter int RUN_BITS    = can_fc_pkg::DEF_RUN_BITS,
    parameter int RUNS_NEEDED = can_fc_pkg::DEF_RUNS_NEEDED,
    localparam int BIT_W      = $clog2(RUN_BITS),
    localparam int RUN_W      = (RUNS_NEEDED > 1) ? $clog2(RUNS_NEEDED) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic strobe_i,
    input  logic rx_i,
    output logic active_o,
    output logic run_done_o,
    output logic seq_done_o
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RUN_BITS - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUNS_NEEDED - 1);

    typedef struct packed {
        logic             active;
        logic [BIT_W-1:0] bits;
        logic [RUN_W-1:0] runs;
    } rcv_state_t;

    rcv_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        run_done_o = 1'b0;
        seq_done_o = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.bits   = '0;
                st_d.runs   = '0;
            end
        end else if (strobe_i) begin
            if (!rx_i) begin
                st_d.bits = '0;
            end else if (st_q.bits == BIT_LAST) begin
                st_d.bits  = '0;
                run_done_o = 1'b1;
                if (st_q.runs == RUN_LAST) begin
                    seq_done_o  = 1'b1;
                    st_d.active = 1'b0;
                    st_d.runs   = '0;
                end else begin
                    st_d.runs = st_q.runs + 1'b1;
                end
            end else begin
                st_d.bits = st_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R7
    runs_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active)) |-> (st_q.runs >= $past(st_q.runs)));

    // R6
    bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits <= BIT_LAST);
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
    parameter int STEP_W        = can_fc_pkg::DEF_STEP_W,
    parameter int WARN_LIMIT    = can_fc_pkg::DEF_WARN_LIMIT,
    parameter int PASSIVE_LIMIT = can_fc_pkg::DEF_PASSIVE_LIMIT,
    parameter int BOFF_LIMIT    = can_fc_pkg::DEF_BOFF_LIMIT,
    parameter int RUN_BITS      = can_fc_pkg::DEF_RUN_BITS,
    parameter int RUNS_NEEDED   = can_fc_pkg::DEF_RUNS_NEEDED,
    localparam int REC_W        = $clog2(BOFF_LIMIT + 1),
    localparam int TEC_W        = REC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] tec_add_i,
    input  logic              tec_dec_i,
    input  logic [STEP_W-1:0] rec_add_i,
    input  logic              rec_dec_i,
    input  logic              bit_strobe_i,
    input  logic              rx_bit_i,
    input  logic              evt_valid_i,
    input  logic [2:0]        evt_code_i,
    input  logic              cpu_init_wr_i,
    input  logic              cpu_init_val_i,
    input  logic              cpu_lec_wr_i,
    input  logic [2:0]        cpu_lec_val_i,
    output logic [TEC_W-1:0]  tec_o,
    output logic [REC_W-1:0]  rec_o,
    output logic              warn_o,
    output logic              passive_o,
    output logic              bus_off_o,
    output logic              init_o,
    output logic [2:0]        lec_o
);
    import can_fc_pkg::*;

    typedef struct packed {
        logic      init;
        lec_code_e lec;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic boff, boff_enter, rcv_active, run_done, seq_done, rcv_start;

    cfc_counters #(
        .STEP_W(STEP_W), .WARN_LIMIT(WARN_LIMIT),
        .PASSIVE_LIMIT(PASSIVE_LIMIT), .BOFF_LIMIT(BOFF_LIMIT)
    ) i_counters (
        .clk(clk), .rst_n(rst_n),
        .tec_add_i(tec_add_i), .tec_dec_i(tec_dec_i),
        .rec_add_i(rec_add_i), .rec_dec_i(rec_dec_i),
        .clear_i(seq_done),
        .tec_o(tec_o), .rec_o(rec_o), .boff_o(boff),
        .boff_enter_o(boff_enter), .warn_o(warn_o), .passive_o(passive_o)
    );

    assign rcv_start = cpu_init_wr_i && !cpu_init_val_i && boff && !rcv_active;

    cfc_recovery #(
        .RUN_BITS(RUN_BITS), .RUNS_NEEDED(RUNS_NEEDED)
    ) i_recovery (
        .clk(clk), .rst_n(rst_n),
        .start_i(rcv_start), .strobe_i(bit_strobe_i), .rx_i(rx_bit_i),
        .active_o(rcv_active), .run_done_o(run_done), .seq_done_o(seq_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (boff_enter)         ctl_d.init = 1'b1;
        else if (cpu_init_wr_i) ctl_d.init = cpu_init_val_i;

        if (run_done)                  ctl_d.lec = LEC_BIT0;
        else if (evt_valid_i && !boff) ctl_d.lec = lec_code_e'(evt_code_i);
        else if (cpu_lec_wr_i)         ctl_d.lec = lec_code_e'(cpu_lec_val_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.init <= 1'b1;
            ctl_q.lec  <= LEC_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_off_o = boff;
    assign init_o    = ctl_q.init;
    assign lec_o     = ctl_q.lec;

    // R4
    boff_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boff) |-> ctl_q.init);

    // R5
    rcv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rcv_active) |-> ($past(cpu_init_wr_i) && !$past(cpu_init_val_i)));

    // R5
    rcv_in_boff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_active |-> boff);

    // R10
    lec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.lec) |->
            ($past(evt_valid_i) || $past(cpu_lec_wr_i) || $past(rcv_active)));

    // R3
    boff_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boff |-> (warn_o && passive_o));
endmodule

// File: tb/test_can_fault_confine.sv
module test_can_fault_confine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tec_add = '0, rec_add = '0;
    logic       tec_dec = 1'b0, rec_dec = 1'b0;
    logic       strobe = 1'b0, rx = 1'b1;
    logic       evt_valid = 1'b0;
    logic [2:0] evt_code = '0;
    logic       iwr = 1'b0, ival = 1'b0, lwr = 1'b0;
    logic [2:0] lval = '0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic       warn, passive, boff, init;
    logic [2:0] lec;
    int         n_chk = 0, n_err = 0;
    bit         wd_fired = 1'b0;

    always #5 clk = ~clk;

    can_fault_confine i_can_fault_confine (
        .clk(clk), .rst_n(rst_n),
        .tec_add_i(tec_add), .tec_dec_i(tec_dec),
        .rec_add_i(rec_add), .rec_dec_i(rec_dec),
        .bit_strobe_i(strobe), .rx_bit_i(rx),
        .evt_valid_i(evt_valid), .evt_code_i(evt_code),
        .cpu_init_wr_i(iwr), .cpu_init_val_i(ival),
        .cpu_lec_wr_i(lwr), .cpu_lec_val_i(lval),
        .tec_o(tec), .rec_o(rec), .warn_o(warn), .passive_o(passive),
        .bus_off_o(boff), .init_o(init), .lec_o(lec)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: inputs set beforehand take effect, pulses cleared after
    task automatic tick();
        @(posedge clk); #1;
        tec_add = '0; rec_add = '0; tec_dec = 0; rec_dec = 0;
        strobe = 0; evt_valid = 0; iwr = 0; lwr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1; tick();
    endtask

    task automatic cpu_init(input logic v);
        iwr = 1; ival = v; tick();
    endtask

    task automatic cpu_lec(input logic [2:0] v);
        lwr = 1; lval = v; tick();
    endtask

    task automatic bits(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin strobe = 1; rx = lvl; tick(); end
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 tec", tec, 0);
        check("R11 rec", rec, 0);
        check("R11 lec", lec, 0);
        check("R11 bus_off", boff, 0);
        check("R11 init", init, 1);
        tec_dec = 1; rec_dec = 1; tick();
        check("R12 tec floor", tec, 0);
        check("R12 rec floor", rec, 0);
    endtask

    task automatic t_thresholds();
        do_reset();
        for (int i = 0; i < 11; i++) begin rec_add = 8; tick(); end
        check("R1 rec=88 warn", warn, 0);
        rec_add = 8; tick();
        check("R1 rec=96 warn", warn, 1);
        rec_dec = 1; tick();
        check("R1 rec=95 warn", warn, 0);
        for (int i = 0; i < 2; i++) begin rec_add = 15; tick(); end
        rec_add = 2; tick();
        check("R2 rec=127 value", rec, 127);
        check("R2 rec=127 passive", passive, 0);
        rec_add = 1; tick();
        check("R2 rec=128 passive", passive, 1);
        for (int i = 0; i < 10; i++) begin rec_add = 15; tick(); end
        check("R12 rec saturates", rec, 255);
        do_reset();
        for (int i = 0; i < 12; i++) begin tec_add = 8; tick(); end
        check("R1 tec=96 warn", warn, 1);
        check("R2 tec=96 passive", passive, 0);
    endtask

    task automatic t_lec();
        do_reset();
        evt_valid = 1; evt_code = 2; tick();
        check("R10 bus event form", lec, 2);
        cpu_lec(7);
        check("R10 cpu writes 7", lec, 7);
        repeat (5) tick();
        check("R10 7 persists", lec, 7);
        evt_valid = 1; evt_code = 6; tick();
        check("R10 crc replaces 7", lec, 6);
        evt_valid = 1; evt_code = 1; lwr = 1; lval = 7; tick();
        check("R10 event wins over cpu", lec, 1);
    endtask

    task automatic t_bus_off_recovery();
        do_reset();
        cpu_init(0);
        check("R4 init cleared", init, 0);
        for (int i = 0; i < 31; i++) begin tec_add = 8; tick(); end
        check("R3 tec=248", tec, 248);
        check("R3 not yet bus-off", boff, 0);
        tec_add = 8; tick();
        check("R3 tec=256 bus-off", boff, 1);
        check("R4 init forced", init, 1);
        tec_add = 8; rec_add = 8; tick();
        check("R3 tec frozen", tec, 256);
        check("R3 rec frozen", rec, 0);
        evt_valid = 1; evt_code = 3; tick();
        check("R3 event ignored", lec, 0);
        // recessive bits before start do not count
        bits(11, 1);
        check("R5 no count before start", lec, 0);
        cpu_init(1);
        bits(11, 1);
        check("R5 write 1 no start", lec, 0);
        cpu_lec(7);
        cpu_init(0);
        check("R5 init cleared starts", init, 0);
        bits(10, 1);
        check("R6 10 bits no code", lec, 7);
        bits(1, 0);
        bits(10, 1);
        check("R7 run restarted", lec, 7);
        bits(1, 1);
        check("R6 run writes Bit0", lec, 5);
        // runs 2..64
        for (int r = 0; r < 63; r++) bits(11, 1);
        bits(4, 1);
        bits(1, 0);
        cpu_init(1);
        cpu_init(0);
        check("R8 still bus-off", boff, 1);
        // runs 65..127
        for (int r = 0; r < 63; r++) bits(11, 1);
        bits(10, 1);
        check("R7 completed runs kept, not done early", boff, 1);
        bits(1, 1);
        check("R9 bus-off cleared", boff, 0);
        check("R9 tec zero", tec, 0);
        check("R9 rec zero", rec, 0);
        check("R9 warn clear", warn, 0);
        check("R9 passive clear", passive, 0);
        check("R8 init left as written", init, 0);
    endtask

    initial begin
        #1500000;
        wd_fired = 1'b1;
    end

    initial begin
        fork
            begin
                t_reset();
                t_thresholds();
                t_lec();
                t_bus_off_recovery();
            end
            begin
                wait (wd_fired);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule